// File: doc/BRIEF.md
# UART Status and Interrupt Control

This block holds the status and interrupt state of a serial port. It keeps three sticky receive error flags (parity, framing, overrun) and the receiver-enable state. None of these can be written directly. They change only through one-hot set and clear bits in a separate write-only command register. Error pulses from the receiver set the flags, but only when the matching detection enable in the control register is on.

The block also keeps a three-source interrupt capture register. Transmit requests, receive requests and recorded errors each set their own bit. Software clears a bit by writing a one to it. An enable mask decides which captured bits drive the per-source interrupt lines. A fourth enable bit passes the transmit-buffer request level straight to its own line.

Software reaches the block through a simple word-indexed write port and a combinational read port. The receiver-enable state is also driven out to the serial engine.

Register indices:

| Index | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read-only |
| 2 | command | write-only |
| 3 | interrupt enable | read/write |
| 4 | interrupt capture | write one to clear |

Top module: `uart_stat_irq`

## Requirements
- R1: After reset, every register reads zero, `rxEnable` is low and all interrupt lines are low.
- R2: Control bit 17 enables framing detection, bit 19 parity detection and bit 20 overrun detection. These three bits read back in place. An error pulse whose detection is disabled changes neither the status nor the capture register.
- R3: Status bit 16 is the parity flag, bit 17 the framing flag and bit 19 the overrun flag. Each flag stays set until its command clear bit is written. Command bit 2 clears parity, bit 3 clears framing and bit 5 clears overrun, and each clears only its own flag.
- R4: An enabled error pulse that arrives in the same cycle as the clear of its flag leaves the flag set.
- R5: Command bit 1 sets the receiver enable and bit 0 clears it; if both are written together, the enable ends up set. The state shows on status bit 0 and on `rxEnable`.
- R6: A command write of all zeros changes no state, and the command register always reads zero.
- R7: Capture bit 0 is set by `txReq`, bit 1 by `rxReq`, and bit 2 by any enabled error pulse. Writing a one to a capture bit clears it, and writing a zero leaves it unchanged. A request arriving in the same cycle as the clear of its bit leaves the bit set.
- R8: Interrupt-enable bits 0, 1 and 2 gate capture bits 0, 1 and 2 onto `irqTx`, `irqRx` and `irqErr`. A masked captured bit stays latched and raises its line once it is enabled.
- R9: `irqTxBuf` is high exactly when interrupt-enable bit 3 is set and `txBufReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | ADDR_W | register index for the write |
| wrData | input | DATA_W | write data |
| rdAddr | input | ADDR_W | register index for the read |
| rdData | output | DATA_W | read data, combinational |
| parityErrPulse | input | 1 | receiver parity error pulse |
| frameErrPulse | input | 1 | receiver framing error pulse |
| overrunPulse | input | 1 | receiver overrun pulse |
| txReq | input | 1 | transmit FIFO request pulse |
| rxReq | input | 1 | receive FIFO request pulse |
| txBufReq | input | 1 | transmit buffer request level |
| rxEnable | output | 1 | receiver enable to the serial engine |
| irqTx | output | 1 | transmit interrupt |
| irqRx | output | 1 | receive interrupt |
| irqErr | output | 1 | error interrupt |
| irqTxBuf | output | 1 | transmit buffer interrupt |

## Verification
The bench drives an error pulse in the same cycle as the clear of its flag, and a transmit request in the same cycle as the write-one-clear of its capture bit. A design that let the clear win would drop an event and read back zero. It fires error pulses with detection disabled and expects no flag and no error capture; a design that ignored the enables would set them. It clears flags one at a time to catch a clear that strikes a neighbouring flag or uses the wrong bit position. It also captures a request while its mask is off and then enables the mask, expecting the line to rise; a design that dropped masked events would keep the line low.

// File: rtl/uart_sic_pkg.sv
package uart_sic_pkg;

  localparam int NUM_ERR = 3;  // 0 parity, 1 framing, 2 overrun
  localparam int NUM_SRC = 3;  // 0 transmit, 1 receive, 2 error

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CMD  = 2;
  localparam int REG_IEN  = 3;
  localparam int REG_CAP  = 4;

  localparam int ERR_STAT_POS [NUM_ERR] = '{16, 17, 19};
  localparam int ERR_DET_POS  [NUM_ERR] = '{19, 17, 20};
  localparam int ERR_CLR_POS  [NUM_ERR] = '{2, 3, 5};
  localparam int CMD_RXEN_CLR = 0;
  localparam int CMD_RXEN_SET = 1;
  localparam int STAT_RXEN    = 0;
  localparam int IEN_W        = 4;
  localparam int IEN_TXBUF    = 3;

  typedef struct packed {
    logic               ctrlLoad;
    logic               ienLoad;
    logic               rxEnSet;
    logic               rxEnClr;
    logic [NUM_ERR-1:0] errClr;
    logic [NUM_SRC-1:0] capClr;
  } strobe_t;

endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import uart_sic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           stb
);

  logic selCtrl, selCmd, selIen, selCap;

  always_comb begin
    selCtrl = wrEn && (wrAddr == ADDR_W'(REG_CTRL));
    selCmd  = wrEn && (wrAddr == ADDR_W'(REG_CMD));
    selIen  = wrEn && (wrAddr == ADDR_W'(REG_IEN));
    selCap  = wrEn && (wrAddr == ADDR_W'(REG_CAP));
  end

  always_comb begin
    stb.ctrlLoad = selCtrl;
    stb.ienLoad  = selIen;
    stb.rxEnSet  = selCmd && wrData[CMD_RXEN_SET];
    stb.rxEnClr  = selCmd && wrData[CMD_RXEN_CLR];
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_errClr
    assign stb.errClr[i] = selCmd && wrData[ERR_CLR_POS[i]];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_capClr
    assign stb.capClr[i] = selCap && wrData[i];
  end

  // R6: without a write strobe, no state-changing strobe is issued
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (stb == '0));

  // R6: a command write never loads a read/write register
  p_cmd_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_W'(REG_CMD)) |-> !(stb.ctrlLoad || stb.ienLoad || |stb.capClr));

endmodule

// File: rtl/sic_data.sv
module sic_data
  import uart_sic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_ERR-1:0] errPulse,
  input  logic               txReq,
  input  logic               rxReq,
  input  logic               txBufReq,
  output logic               rxEnable,
  output logic [NUM_SRC-1:0] irqSrc,
  output logic               irqTxBuf
);

  logic [NUM_ERR-1:0] detEn, errFlag, errHit;
  logic [NUM_SRC-1:0] cap, capSet;
  logic [IEN_W-1:0]   ien;
  logic               rxEnR;

  assign errHit = errPulse & detEn;
  assign capSet = {|errHit, rxReq, txReq};

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                detEn[i] <= 1'b0;
      else if (stb.ctrlLoad)     detEn[i] <= wrData[ERR_DET_POS[i]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                errFlag[i] <= 1'b0;
      else if (errHit[i])        errFlag[i] <= 1'b1;
      else if (stb.errClr[i])    errFlag[i] <= 1'b0;
    end

    // R3: a set flag holds until its clear strobe
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (errFlag[i] && !stb.errClr[i]) |=> errFlag[i]);
    // R4: an enabled pulse always leaves the flag set, clear or not
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (errPulse[i] && detEn[i]) |=> errFlag[i]);
    // R2: with detection off, a clear flag stays clear
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!detEn[i] && !errFlag[i]) |=> !errFlag[i]);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cap[i] <= 1'b0;
      else if (capSet[i])        cap[i] <= 1'b1;
      else if (stb.capClr[i])    cap[i] <= 1'b0;
    end

    assign irqSrc[i] = cap[i] & ien[i];

    // R7: a captured bit stays latched until written with one
    p_cap_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap[i] && !stb.capClr[i]) |=> cap[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ien <= '0;
    else if (stb.ienLoad)  ien <= wrData[IEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rxEnR <= 1'b0;
    else if (stb.rxEnSet)  rxEnR <= 1'b1;
    else if (stb.rxEnClr)  rxEnR <= 1'b0;
  end

  assign rxEnable = rxEnR;
  assign irqTxBuf = ien[IEN_TXBUF] & txBufReq;

  // R5: a set command always leaves the receiver enabled
  p_rxen_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rxEnSet |=> rxEnable);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(REG_CTRL): for (int i = 0; i < NUM_ERR; i++) rdData[ERR_DET_POS[i]] = detEn[i];
      ADDR_W'(REG_STAT): begin
        rdData[STAT_RXEN] = rxEnR;
        for (int i = 0; i < NUM_ERR; i++) rdData[ERR_STAT_POS[i]] = errFlag[i];
      end
      ADDR_W'(REG_IEN):  rdData[IEN_W-1:0] = ien;
      ADDR_W'(REG_CAP):  rdData[NUM_SRC-1:0] = cap;
      default:           rdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_sic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              parityErrPulse,
  input  logic              frameErrPulse,
  input  logic              overrunPulse,
  input  logic              txReq,
  input  logic              rxReq,
  input  logic              txBufReq,
  output logic              rxEnable,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqErr,
  output logic              irqTxBuf
);

  strobe_t            stb;
  logic [NUM_SRC-1:0] irqSrc;

  sic_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb)
  );

  sic_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .errPulse ({overrunPulse, frameErrPulse, parityErrPulse}),
    .txReq    (txReq),
    .rxReq    (rxReq),
    .txBufReq (txBufReq),
    .rxEnable (rxEnable),
    .irqSrc   (irqSrc),
    .irqTxBuf (irqTxBuf)
  );

  assign irqTx  = irqSrc[0];
  assign irqRx  = irqSrc[1];
  assign irqErr = irqSrc[2];

endmodule

// File: tb/sim_uart_stat_irq.sv
`timescale 1ns/1ps
module sim_uart_stat_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        pe = 1'b0, fe = 1'b0, oe = 1'b0, txReq = 1'b0, rxReq = 1'b0, txBufReq = 1'b0;
  logic        rxEnable, irqTx, irqRx, irqErr, irqTxBuf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_stat_irq u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .parityErrPulse(pe), .frameErrPulse(fe), .overrunPulse(oe),
    .txReq(txReq), .rxReq(rxReq), .txBufReq(txBufReq),
    .rxEnable(rxEnable), .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr), .irqTxBuf(irqTxBuf)
  );

  localparam logic [2:0] A_CTRL = 0, A_STAT = 1, A_CMD = 2, A_IEN = 3, A_CAP = 4;
  localparam logic [31:0] S_PE = 32'h1_0000, S_FE = 32'h2_0000, S_OE = 32'h8_0000;
  localparam logic [31:0] C_ALL = 32'h1A_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: optional write plus event inputs, released at the next negedge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic p, input logic f, input logic o,
                     input logic tr, input logic rr);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d;
    pe = p; fe = f; oe = o; txReq = tr; rxReq = rr;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; pe = 0; fe = 0; oe = 0; txReq = 0; rxReq = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset rxEnable/irqs", {27'd0, rxEnable, irqTx, irqRx, irqErr, irqTxBuf}, 0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    cyc(0, 0, 0, 1, 1, 1, 0, 0);
    rd(A_STAT, v); chk("R2 disabled errors ignored (status)", v, 0);
    rd(A_CAP, v);  chk("R2 disabled errors ignored (capture)", v, 0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 control enables read back", v, C_ALL);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    rd(A_STAT, v); chk("R2 parity flag bit16", v, S_PE);
    rd(A_CAP, v);  chk("R7 error capture bit2", v, 32'h4);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    rd(A_STAT, v); chk("R3 all three flags", v, S_PE | S_FE | S_OE);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(A_CMD, 32'h8);
    rd(A_STAT, v); chk("R3 clear framing only", v, S_PE | S_OE);
    wr(A_CMD, 32'h4);
    rd(A_STAT, v); chk("R3 clear parity only", v, S_OE);
    wr(A_CMD, 32'h20);
    rd(A_STAT, v); chk("R3 clear overrun", v, 0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    cyc(1, A_CMD, 32'h4, 1, 0, 0, 0, 0);
    rd(A_STAT, v); chk("R4 set wins over clear", v, S_PE);
    wr(A_CMD, 32'h4);
    rd(A_STAT, v); chk("R4 later clear works", v, 0);
  endtask

  task automatic t_rxen;
    logic [31:0] v;
    wr(A_CMD, 32'h2);
    rd(A_STAT, v); chk("R5 set receiver enable", {v[31:1], rxEnable}, 32'h1);
    wr(A_CMD, 32'h1);
    rd(A_STAT, v); chk("R5 clear receiver enable", {v[31:1], rxEnable} | {31'd0, v[0]}, 0);
    wr(A_CMD, 32'h3);
    chk("R5 both bits: set wins", {31'd0, rxEnable}, 1);
  endtask

  task automatic t_cmdzero;
    logic [31:0] v;
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    wr(A_CMD, 32'h0);
    rd(A_STAT, v); chk("R6 zero command no effect", v, S_FE | 32'h1);
    rd(A_CMD, v);  chk("R6 command reads zero", v, 0);
    wr(A_CMD, 32'h29);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    rd(A_CAP, v); chk("R7 tx/rx/err captured", v, 32'h7);
    wr(A_CAP, 32'h0);
    rd(A_CAP, v); chk("R7 zero write keeps bits", v, 32'h7);
    wr(A_CAP, 32'h2);
    rd(A_CAP, v); chk("R7 write one clears rx only", v, 32'h5);
    cyc(1, A_CAP, 32'h1, 0, 0, 0, 1, 0);
    rd(A_CAP, v); chk("R7 request wins over clear", v, 32'h5);
    wr(A_CAP, 32'h5);
    rd(A_CAP, v); chk("R7 clear all", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 masked capture no irq", {31'd0, irqTx}, 0);
    rd(A_CAP, v); chk("R8 masked capture latched", v, 32'h1);
    wr(A_IEN, 32'h1);
    rd(A_IEN, v); chk("R8 enable readback", v, 32'h1);
    chk("R8 irqTx after unmask", {31'd0, irqTx}, 1);
    wr(A_CAP, 32'h1);
    chk("R8 irqTx drops on clear", {31'd0, irqTx}, 0);
    wr(A_IEN, 32'hF);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 irqRx only", {29'd0, irqTx, irqRx, irqErr}, 32'h2);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 irqErr raised", {29'd0, irqTx, irqRx, irqErr}, 32'h3);
  endtask

  task automatic t_txbuf;
    txBufReq = 1'b1; #1;
    chk("R9 txbuf enabled", {31'd0, irqTxBuf}, 1);
    wr(A_IEN, 32'h7);
    chk("R9 txbuf masked", {31'd0, irqTxBuf}, 0);
    txBufReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gate;
    t_clear;
    t_race;
    t_rxen;
    t_cmdzero;
    t_capture;
    t_mask;
    t_txbuf;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule